// File: doc/BRIEF.md
# Queue Accumulator Interrupt Coalescer

This block sits beside a hardware message queue and decides when the core that drains the queue should be interrupted. Each cycle, any number of writer lanes may signal that a descriptor was pushed into the queue. The block keeps a running count of messages not yet consumed and raises an interrupt according to a selectable policy. It can interrupt on every arrival, interrupt only once enough messages have gathered, or interrupt once a waiting message has sat too long. The last two run together in accumulate mode, and the first to trigger wins. In polling mode it never interrupts, and the consumer reads the pending count instead.

The consumer clears the interrupt with an acknowledge pulse. The pulse carries how many entries were drained, and the block subtracts that number from the pending count. Descriptor storage, copying and software signalling stay outside the block.

Top module: `qacc_irq_coalescer`

## Requirements
- R1: Mode encoding on `mode_i`: 0 and 3 are polling, 1 is direct and 2 is accumulate. In polling mode no new interrupt is raised, whatever the pushes.
- R2: In accumulate mode, `irq_o` rises on the clock edge at which the pending count becomes greater than or equal to the watermark `wmark_i`.
- R3: In direct mode, any cycle with at least one push raises `irq_o` on that clock edge.
- R4: In accumulate mode, when messages are pending and no interrupt is active, `irq_o` rises exactly `tmo_i` cycles after the pending count last became nonzero or after the interrupt last fell. The timer counts only while `irq_o` is low and the count is nonzero, and it restarts at zero whenever an interrupt is raised.
- R5: A watermark of 0 behaves as a watermark of 1, and a timeout of 0 behaves as a timeout of 1.
- R6: `irq_o` stays high until an `ack_i` cycle in which no new interrupt condition holds, and it falls on that edge.
- R7: Each edge, the pending count gains the number of set bits in `push_i` and loses `ack_cnt_i` when `ack_i` is high. The subtraction is limited to the pending count, and both changes apply when they occur in the same cycle.
- R8: The pending count saturates at 2^CNT_W-1. A saturating update sets `ovf_o`, which then stays high until reset.
- R9: A synchronous active-high `rst` clears the pending count, `irq_o`, `ovf_o` and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | NUM_SRC | One push strobe per writer lane |
| mode_i | input | 2 | Interrupt policy (0/3 poll, 1 direct, 2 accumulate) |
| wmark_i | input | CNT_W | Accumulate watermark |
| tmo_i | input | TMR_W | Accumulate timeout in cycles |
| ack_i | input | 1 | Consumer acknowledge |
| ack_cnt_i | input | CNT_W | Entries drained with this acknowledge |
| irq_o | output | 1 | Interrupt to consumer |
| pend_o | output | CNT_W | Current pending count |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with three writer lanes, a 5-bit count and a 6-bit timer. With these values, eleven cycles of full pushes drive the count past its ceiling of 31, so saturation and the sticky flag come up within a short directed run. Timeouts of at most 63 cycles let random stimulus expire the timer many times. The random traffic also covers all four mode codes, watermark and timeout values of zero, and acknowledges that ask to drain more than is pending.

// File: rtl/qacc_pkg.sv
package qacc_pkg;
  typedef enum logic [1:0] {
    QC_POLL   = 2'd0,
    QC_DIRECT = 2'd1,
    QC_ACCUM  = 2'd2,
    QC_POLL2  = 2'd3
  } qc_mode_e;
endpackage

// File: rtl/qc_src_merge.sv
module qc_src_merge #(
  parameter int NUM_SRC = 4,
  parameter int OUT_W   = 3
) (
  input  logic [NUM_SRC-1:0] push_i,
  output logic [OUT_W-1:0]   add_o
);
  always_comb begin
    add_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      add_o = add_o + OUT_W'(push_i[i]);
    end
  end
endmodule

// File: rtl/qc_pend_count.sv
module qc_pend_count #(
  parameter int CNT_W = 8,
  parameter int ADD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADD_W-1:0] add_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] ack_cnt_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf_q
);
  localparam int SUM_W = ((CNT_W > ADD_W) ? CNT_W : ADD_W) + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] sub;
  logic [SUM_W-1:0] sum;
  logic             sat;

  always_comb begin
    sub = '0;
    if (ack_i) sub = (ack_cnt_i > cnt_q) ? cnt_q : ack_cnt_i;
    sum = SUM_W'(cnt_q - sub) + SUM_W'(add_i);
    sat = (sum > CNT_MAX);
    cnt_nxt = sat ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (sat) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/qc_timer.sv
module qc_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             hit_o
);
  logic [TMR_W-1:0] t_q;

  assign hit_o = run_i && (t_q >= limit_i - TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || clr_i) t_q <= '0;
    else                        t_q <= t_q + TMR_W'(1);
  end
endmodule

// File: rtl/qc_irq_gen.sv
module qc_irq_gen
  import qacc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  qc_mode_e         mode_i,
  input  logic             any_push_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] wm_i,
  input  logic             hit_i,
  input  logic             ack_i,
  output logic             set_o,
  output logic             irq_q
);
  always_comb begin
    unique case (mode_i)
      QC_DIRECT: set_o = any_push_i;
      QC_ACCUM:  set_o = (cnt_nxt_i >= wm_i) || hit_i;
      default:   set_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= set_o || (irq_q && !ack_i);
  end
endmodule

// File: rtl/qacc_irq_coalescer.sv
module qacc_irq_coalescer
  import qacc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] push_i,
  input  logic [1:0]         mode_i,
  input  logic [CNT_W-1:0]   wmark_i,
  input  logic [TMR_W-1:0]   tmo_i,
  input  logic               ack_i,
  input  logic [CNT_W-1:0]   ack_cnt_i,
  output logic               irq_o,
  output logic [CNT_W-1:0]   pend_o,
  output logic               ovf_o
);
  localparam int ADD_W = $clog2(NUM_SRC + 1);

  qc_mode_e         mode;
  logic [ADD_W-1:0] add;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, wm_eff;
  logic [TMR_W-1:0] to_eff;
  logic             run, hit, set, irq_q;

  assign mode   = qc_mode_e'(mode_i);
  assign wm_eff = (wmark_i == '0) ? CNT_W'(1) : wmark_i;
  assign to_eff = (tmo_i == '0) ? TMR_W'(1) : tmo_i;
  assign run    = (mode == QC_ACCUM) && (cnt_q != '0) && !irq_q;

  qc_src_merge #(.NUM_SRC(NUM_SRC), .OUT_W(ADD_W)) u_merge (
    .push_i (push_i),
    .add_o  (add)
  );

  qc_pend_count #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .add_i     (add),
    .ack_i     (ack_i),
    .ack_cnt_i (ack_cnt_i),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .ovf_q     (ovf_o)
  );

  qc_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .clr_i   (set),
    .limit_i (to_eff),
    .hit_o   (hit)
  );

  qc_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .any_push_i (add != '0),
    .cnt_nxt_i  (cnt_nxt),
    .wm_i       (wm_eff),
    .hit_i      (hit),
    .ack_i      (ack_i),
    .set_o      (set),
    .irq_q      (irq_q)
  );

  assign irq_o  = irq_q;
  assign pend_o = cnt_q;
endmodule

// File: rtl/qacc_irq_coalescer_chk.sv
module qacc_irq_coalescer_chk #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] push_i,
  input logic [1:0]         mode_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [CNT_W-1:0]   pend_o,
  input logic               ovf_o
);
  // R1: polling mode never raises a new interrupt
  a_r1_poll_quiet: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 2'd0 || mode_i == 2'd3) && !irq_o) |=> !irq_o);

  // R3: direct mode interrupts on any push
  a_r3_direct_fire: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && push_i != '0) |=> irq_o);

  // R6: acknowledge without push in direct mode drops the line
  a_r6_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && ack_i && push_i == '0) |=> !irq_o);

  // R7: with no acknowledge the count never decreases
  a_r7_no_loss: assert property (@(posedge clk) disable iff (rst)
    (!ack_i) |=> (pend_o >= $past(pend_o)));

  // R8: sticky overflow, raised only at full count
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  a_r8_ovf_at_max: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> (pend_o == {CNT_W{1'b1}}));

  // R2: accumulate mode with an empty queue and no push stays quiet
  a_r2_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && pend_o == '0 && push_i == '0 && !irq_o) |=> !irq_o);
endmodule

bind qacc_irq_coalescer qacc_irq_coalescer_chk #(
  .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .mode_i(mode_i), .ack_i(ack_i),
  .irq_o(irq_o), .pend_o(pend_o), .ovf_o(ovf_o)
);

// File: tb/test_qacc_irq_coalescer.sv
module test_qacc_irq_coalescer;
  localparam int NS = 3;
  localparam int CW = 5;
  localparam int TW = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] push = '0;
  logic [1:0]    mode = 2'd0;
  logic [CW-1:0] wmark = '0;
  logic [TW-1:0] tmo = '0;
  logic          ack = 1'b0;
  logic [CW-1:0] ackc = '0;
  logic          irq;
  logic [CW-1:0] pend;
  logic          ovf;

  int checks = 0;
  int fails  = 0;

  // reference state
  int m_pend, m_t;
  bit m_irq, m_ovf;

  always #2.5 clk = ~clk;

  qacc_irq_coalescer #(.NUM_SRC(NS), .CNT_W(CW), .TMR_W(TW)) i_qacc_irq_coalescer (
    .clk(clk), .rst(rst), .push_i(push), .mode_i(mode), .wmark_i(wmark),
    .tmo_i(tmo), .ack_i(ack), .ack_cnt_i(ackc),
    .irq_o(irq), .pend_o(pend), .ovf_o(ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [NS-1:0] v);
    int n = 0;
    for (int i = 0; i < NS; i++) n += v[i];
    return n;
  endfunction

  // one clock of the reference model, from the requirements
  task automatic step();
    int add, sub, s, wm, to, n_irq, n_t;
    bit run, hit, set;
    add = ones(push);
    sub = ack ? ((ackc > m_pend) ? m_pend : ackc) : 0;  // R7
    s = m_pend - sub + add;
    wm = (wmark == 0) ? 1 : wmark;                     // R5
    to = (tmo == 0) ? 1 : tmo;
    run = (mode == 2) && (m_pend != 0) && !m_irq;      // R4
    hit = run && (m_t >= to - 1);
    case (mode)
      2'd1:    set = (add != 0);                       // R3
      2'd2:    set = (s >= wm) || hit;                 // R2
      default: set = 1'b0;                             // R1
    endcase
    n_irq = set || (m_irq && !ack);                    // R6
    n_t = (!run || set) ? 0 : m_t + 1;
    @(posedge clk);
    if (s > MAXC) begin s = MAXC; m_ovf = 1; end       // R8
    m_pend = s; m_irq = n_irq; m_t = n_t;
    @(negedge clk);
    check("R7 pending model", pend, m_pend);
    check("R6 irq model", irq, m_irq);
    check("R8 ovf model", ovf, m_ovf);
  endtask

  task automatic idle_in();
    push = '0; ack = 1'b0; ackc = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle_in();
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_pend = 0; m_t = 0; m_irq = 0; m_ovf = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R9: reset state
    check("R9 pend", pend, 0); check("R9 irq", irq, 0); check("R9 ovf", ovf, 0);

    // R1: polling ignores pushes, count still visible
    mode = 2'd0; push = 3'b111; step(); push = 3'b001; step(); idle_in();
    check("R1 no irq", irq, 0); check("R1 poll count", pend, 4);
    mode = 2'd3; push = 3'b010; step(); idle_in();
    check("R1 code3 no irq", irq, 0);
    ack = 1; ackc = 5'd9; step(); idle_in();
    check("R7 ack clamps at zero", pend, 0);

    // R3 / R6: direct mode
    mode = 2'd1; push = 3'b100; step(); idle_in();
    check("R3 direct fire", irq, 1);
    step(); check("R6 held", irq, 1);
    ack = 1; ackc = 5'd1; step(); idle_in();
    check("R6 ack drop", irq, 0); check("R7 ack count", pend, 0);

    // R2: watermark 4, timeout long
    mode = 2'd2; wmark = 5'd4; tmo = 6'd60;
    for (int i = 0; i < 3; i++) begin push = 3'b001; step(); end
    idle_in(); check("R2 below mark", irq, 0);
    push = 3'b001; step(); idle_in();
    check("R2 at mark", irq, 1);
    ack = 1; ackc = 5'd4; step(); idle_in(); check("R6 accum ack", irq, 0);

    // R5: watermark 0 acts as 1
    wmark = 5'd0; push = 3'b010; step(); idle_in();
    check("R5 wm zero", irq, 1);
    ack = 1; ackc = 5'd1; step(); idle_in();

    // R4: timeout of 5 cycles
    wmark = 5'd20; tmo = 6'd5; push = 3'b001; step(); idle_in();
    for (int i = 0; i < 4; i++) step();
    check("R4 before timeout", irq, 0);
    step(); check("R4 timeout fires", irq, 1);

    // R7: simultaneous push and ack
    do_reset(); mode = 2'd0;
    push = 3'b111; step();
    push = 3'b001; ack = 1; ackc = 5'd2; step(); idle_in();
    check("R7 push+ack", pend, 2);

    // R5: timeout 0 acts as 1
    mode = 2'd2; wmark = 5'd30; tmo = 6'd0; step();
    check("R5 tmo zero", irq, 1);

    // R8: saturation
    mode = 2'd0; ack = 1; ackc = 5'd31; step(); idle_in();
    for (int i = 0; i < 11; i++) begin push = 3'b111; step(); end
    idle_in();
    check("R8 saturate", pend, MAXC); check("R8 flag", ovf, 1);
    ack = 1; ackc = 5'd31; step(); idle_in();
    check("R8 sticky", ovf, 1);

    // random traffic
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) < 3) begin
        mode = 2'($urandom_range(0, 3));
        wmark = CW'($urandom_range(0, 12));
        tmo = TW'($urandom_range(0, 20));
      end
      push = NS'($urandom_range(0, 7) & (($urandom_range(0, 3) == 0) ? 7 : 1));
      ack = ($urandom_range(0, 9) == 0) || (irq && $urandom_range(0, 3) == 0);
      ackc = CW'($urandom_range(0, 12));
      step();
      if (i == 1500) do_reset();
    end
    idle_in();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule